// File: doc/BRIEF.md
# Compressed Instruction Expander

This block turns a 16-bit compressed instruction from the 32-bit integer subset of RISC-V into the 32-bit base instruction that has the same effect. A decode stage uses it after fetch has aligned a halfword. The stage presents the halfword with a valid strobe. One clock later the block returns the full-width instruction, a valid flag and an illegal flag. The execution stage then handles every instruction as if it had arrived in base form.

The block rebuilds immediates from their scattered bit positions. It maps the 3-bit register fields onto x8 to x15. It also settles the encodings that share an opcode slot, using a fixed priority. Reserved encodings produce the illegal flag. So do the encodings that belong to floating-point, 64-bit or 128-bit variants, and the whole non-compressed quadrant. When the flag is set, the instruction output is all zeros.

A jump that writes a link register expands with rd = x1, and a plain jump expands with rd = x0. The block does not encode the 2-byte link increment; the execution stage accounts for it.

Top module: `cinstr_expand`

## Requirements
- R1: Outputs are registered. `outValid` in a cycle equals `inValid` at the previous rising clock edge, and `outInstr`/`outIllegal` describe the halfword captured at that same edge.
- R2: After reset, and in any cycle where `outValid` is 0, `outInstr` is 0 and `outIllegal` is 0. This holds even when the halfword presented without a strobe is illegal.
- R3: A 3-bit register field (bits 9:7 or bits 4:2) names register 8 plus the field value. Bits 1:0 select quadrant 00, 01 or 10, and bits 15:13 select the operation within the quadrant.
- R4: Loads, stores and the stack-pointer add (ADDI4SPN) use zero-extended, word-scaled offsets. For word load/store: offset[5:3] = bits 12:10, offset[2] = bit 6, offset[6] = bit 5. For stack-relative load: offset[5] = bit 12, offset[4:2] = bits 6:4, offset[7:6] = bits 3:2. For stack-relative store: offset[5:2] = bits 12:9, offset[7:6] = bits 8:7. For ADDI4SPN: offset[9:6] = bits 10:7, offset[5:4] = bits 12:11, offset[3] = bit 5, offset[2] = bit 6.
- R5: Both jumps take a sign-extended offset. offset[11] = bit 12, [10] = bit 8, [9:8] = bits 10:9, [7] = bit 6, [6] = bit 7, [5] = bit 2, [4] = bit 11, [3:1] = bits 5:3. Quadrant 01 funct3 001 links to x1, and funct3 101 uses x0.
- R6: Zero-test branches take a sign-extended offset. [8] = bit 12, [7:6] = bits 6:5, [5] = bit 2, [4:3] = bits 11:10, [2:1] = bits 4:3. funct3 110 gives branch-if-equal against x0 and funct3 111 gives branch-if-not-equal.
- R7: Immediate arithmetic (add-immediate, load-immediate, and-immediate, load-upper, and the three shifts) uses the 6-bit field formed by bit 12 and bits 6:2. The field is sign-extended except for shift amounts.
- R8: Quadrant 01 funct3 100 with bits 11:10 = 11 and bit 12 = 0 selects subtract, xor, or, and by bits 6:5 = 00, 01, 10, 11 on the compact registers.
- R9: In quadrant 10 funct3 100, bit 12 = 0 gives move (rs2 ≠ 0) or jump-register with rd = x0 (rs2 = 0). Bit 12 = 1 gives add (rs2 ≠ 0), jump-register with rd = x1 (rs2 = 0, rs1 ≠ 0), or breakpoint 0x00100073 (both zero).
- R10: In quadrant 01 funct3 011, rd = 2 selects the stack-pointer adjust (x2 += offset). Its offset[9] = bit 12, [8:7] = bits 4:3, [6] = bit 5, [5] = bit 2, [4] = bit 6, sign-extended. Any other rd selects load-upper.
- R11: The following are flagged illegal: the all-zero word, ADDI4SPN with a zero offset, load-upper with rd = 0 or a zero immediate, stack-pointer adjust with a zero offset, load-immediate with rd = 0, and left shift with rd = 0.
- R12: The following are flagged illegal: quadrant 11, quadrant 00 funct3 other than 000/010/110, quadrant 10 funct3 001/011/101/111, any of the three shifts with bit 12 set, and quadrant 01 funct3 100 with bit 12 set and bits 11:10 = 11.
- R13: Whenever `outIllegal` is 1, `outInstr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Halfword strobe |
| inHalf | input | 16 | Compressed instruction |
| outValid | output | 1 | Registered strobe, one cycle after `inValid` |
| outInstr | output | 32 | Expanded base instruction, zero when illegal or idle |
| outIllegal | output | 1 | Input halfword was illegal or reserved |

## Verification
The bench targets bit-level immediate reassembly by driving one offset bit at a time. A swapped pair such as the two jump bits 6 and 7, or the two load bits 5 and 6, shifts the target or address by a visible power of two. It probes the overlapping slots: load-upper against stack-pointer adjust, and move/jump-register/add/jump-and-link/breakpoint. A wrong priority there expands a breakpoint into an add, or a jump into a move. It also drives every reserved and out-of-subset encoding. A design that only scatters fields would return a plausible but wrong instruction for these, instead of the illegal flag with a zero word.

// File: rtl/cinstr_expand_pkg.sv
package cinstr_expand_pkg;

  localparam int HALF_W   = 16;
  localparam int WORD_W   = 32;
  localparam int REG_W    = 5;
  localparam int CREG_W   = 3;
  localparam int CREG_BASE = 8;
  localparam int IMM_W    = 12;

  localparam logic [6:0] OPC_OPIMM  = 7'h13;
  localparam logic [6:0] OPC_OP     = 7'h33;
  localparam logic [6:0] OPC_LUI    = 7'h37;
  localparam logic [6:0] OPC_LOAD   = 7'h03;
  localparam logic [6:0] OPC_STORE  = 7'h23;
  localparam logic [6:0] OPC_BRANCH = 7'h63;
  localparam logic [6:0] OPC_JAL    = 7'h6F;
  localparam logic [6:0] OPC_JALR   = 7'h67;
  localparam logic [WORD_W-1:0] BREAK_WORD = 32'h0010_0073;

  localparam logic [REG_W-1:0] REG_ZERO = 5'd0;
  localparam logic [REG_W-1:0] REG_LINK = 5'd1;
  localparam logic [REG_W-1:0] REG_SP   = 5'd2;

  typedef enum logic [4:0] {
    OP_NONE, OP_ADDI4SPN, OP_LW, OP_SW, OP_ADDI, OP_JAL, OP_LI, OP_ADDI16SP,
    OP_LUI, OP_SRLI, OP_SRAI, OP_ANDI, OP_SUB, OP_XOR, OP_OR, OP_AND,
    OP_J, OP_BEQZ, OP_BNEZ, OP_SLLI, OP_LWSP, OP_MV, OP_JR, OP_ADD,
    OP_JALR, OP_EBREAK, OP_SWSP
  } cOp_e;

  typedef struct packed {
    logic take;
    logic bad;
    cOp_e op;
  } ctrlStrobe_t;

  function automatic logic [WORD_W-1:0] encI(logic [IMM_W-1:0] imm, logic [REG_W-1:0] rs1,
                                             logic [2:0] f3, logic [REG_W-1:0] rd, logic [6:0] opc);
    return {imm, rs1, f3, rd, opc};
  endfunction

  function automatic logic [WORD_W-1:0] encR(logic [6:0] f7, logic [REG_W-1:0] rs2, logic [REG_W-1:0] rs1,
                                             logic [2:0] f3, logic [REG_W-1:0] rd);
    return {f7, rs2, rs1, f3, rd, OPC_OP};
  endfunction

  function automatic logic [WORD_W-1:0] encS(logic [IMM_W-1:0] imm, logic [REG_W-1:0] rs2,
                                             logic [REG_W-1:0] rs1);
    return {imm[11:5], rs2, rs1, 3'b010, imm[4:0], OPC_STORE};
  endfunction

  function automatic logic [WORD_W-1:0] encB(logic [12:0] imm, logic [REG_W-1:0] rs1, logic [2:0] f3);
    return {imm[12], imm[10:5], REG_ZERO, rs1, f3, imm[4:1], imm[11], OPC_BRANCH};
  endfunction

  function automatic logic [WORD_W-1:0] encJ(logic [20:0] imm, logic [REG_W-1:0] rd);
    return {imm[20], imm[10:1], imm[11], imm[19:12], rd, OPC_JAL};
  endfunction

endpackage

// File: rtl/cinstr_expand_ctrl.sv
module cinstr_expand_ctrl
  import cinstr_expand_pkg::*;
(
  input  logic              inValid,
  input  logic [HALF_W-1:0] half,
  output ctrlStrobe_t       strobe
);

  logic [2:0]       funct3;
  logic             bit12;
  logic [REG_W-1:0] rdFull;
  logic [REG_W-1:0] rs2Full;
  logic             immZero;
  cOp_e             op;
  logic             bad;

  assign funct3  = half[15:13];
  assign bit12   = half[12];
  assign rdFull  = half[11:7];
  assign rs2Full = half[6:2];
  assign immZero = ({bit12, half[6:2]} == 6'd0);

  always_comb begin
    op  = OP_NONE;
    bad = 1'b0;
    case (half[1:0])
      2'b00: begin
        case (funct3)
          3'b000: if (half[12:5] == 8'd0) bad = 1'b1; else op = OP_ADDI4SPN;
          3'b010: op = OP_LW;
          3'b110: op = OP_SW;
          default: bad = 1'b1;
        endcase
      end
      2'b01: begin
        case (funct3)
          3'b000: op = OP_ADDI;
          3'b001: op = OP_JAL;
          3'b010: if (rdFull == REG_ZERO) bad = 1'b1; else op = OP_LI;
          3'b011: begin
            if (rdFull == REG_SP) begin
              if (immZero) bad = 1'b1; else op = OP_ADDI16SP;
            end else if (rdFull == REG_ZERO || immZero) begin
              bad = 1'b1;
            end else begin
              op = OP_LUI;
            end
          end
          3'b100: begin
            case (half[11:10])
              2'b00: if (bit12) bad = 1'b1; else op = OP_SRLI;
              2'b01: if (bit12) bad = 1'b1; else op = OP_SRAI;
              2'b10: op = OP_ANDI;
              default: begin
                if (bit12) bad = 1'b1;
                else begin
                  case (half[6:5])
                    2'b00:   op = OP_SUB;
                    2'b01:   op = OP_XOR;
                    2'b10:   op = OP_OR;
                    default: op = OP_AND;
                  endcase
                end
              end
            endcase
          end
          3'b101: op = OP_J;
          3'b110: op = OP_BEQZ;
          default: op = OP_BNEZ;
        endcase
      end
      2'b10: begin
        case (funct3)
          3'b000: if (bit12 || rdFull == REG_ZERO) bad = 1'b1; else op = OP_SLLI;
          3'b010: op = OP_LWSP;
          3'b100: begin
            if (!bit12) begin
              op = (rs2Full != REG_ZERO) ? OP_MV : OP_JR;
            end else if (rs2Full != REG_ZERO) begin
              op = OP_ADD;
            end else if (rdFull != REG_ZERO) begin
              op = OP_JALR;
            end else begin
              op = OP_EBREAK;
            end
          end
          3'b110: op = OP_SWSP;
          default: bad = 1'b1;
        endcase
      end
      default: bad = 1'b1;
    endcase
  end

  assign strobe.take = inValid;
  assign strobe.bad  = bad;
  assign strobe.op   = bad ? OP_NONE : op;

  // Immediate checks on the decode result against raw halfword patterns
  always_comb begin
    if (half == '0) begin
      a_r11_zero_word_bad: assert (strobe.bad);
    end
    if (half[1:0] == 2'b11) begin
      a_r12_quadrant3_bad: assert (strobe.bad && strobe.op == OP_NONE);
    end
  end

endmodule

// File: rtl/cinstr_expand_dp.sv
module cinstr_expand_dp
  import cinstr_expand_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [12:2]       fld,
  input  ctrlStrobe_t       strobe,
  output logic              outValid,
  output logic [WORD_W-1:0] outInstr,
  output logic              outIllegal
);

  logic [REG_W-1:0] rdFull, rs2Full, rdComp, rsComp;
  logic [IMM_W-1:0] immSpn, immWord, immLwsp, immSwsp, immSmall, immSp16;
  logic [19:0]      immUpper;
  logic [11:0]      offJ;
  logic [8:0]       offB;
  logic [20:0]      offJext;
  logic [12:0]      offBext;
  logic [4:0]       shamt;
  logic [WORD_W-1:0] wordNext;

  assign rdFull  = fld[11:7];
  assign rs2Full = fld[6:2];
  assign rdComp  = REG_W'(CREG_BASE) + REG_W'(fld[4:2]);
  assign rsComp  = REG_W'(CREG_BASE) + REG_W'(fld[9:7]);
  assign shamt   = fld[6:2];

  // Zero-extended, word-scaled offsets
  assign immSpn  = {2'b00, fld[10:7], fld[12:11], fld[5], fld[6], 2'b00};
  assign immWord = {5'd0, fld[5], fld[12:10], fld[6], 2'b00};
  assign immLwsp = {4'd0, fld[3:2], fld[12], fld[6:4], 2'b00};
  assign immSwsp = {4'd0, fld[8:7], fld[12:9], 2'b00};

  // Sign-extended immediates
  assign immSmall = {{6{fld[12]}}, fld[12], fld[6:2]};
  assign immUpper = {{14{fld[12]}}, fld[12], fld[6:2]};
  assign immSp16  = {{2{fld[12]}}, fld[12], fld[4:3], fld[5], fld[2], fld[6], 4'd0};
  assign offJ     = {fld[12], fld[8], fld[10:9], fld[6], fld[7], fld[2], fld[11], fld[5:3], 1'b0};
  assign offB     = {fld[12], fld[6:5], fld[2], fld[11:10], fld[4:3], 1'b0};
  assign offJext  = {{9{offJ[11]}}, offJ};
  assign offBext  = {{4{offB[8]}}, offB};

  always_comb begin
    wordNext = '0;
    case (strobe.op)
      OP_ADDI4SPN: wordNext = encI(immSpn, REG_SP, 3'b000, rdComp, OPC_OPIMM);
      OP_LW:       wordNext = encI(immWord, rsComp, 3'b010, rdComp, OPC_LOAD);
      OP_SW:       wordNext = encS(immWord, rdComp, rsComp);
      OP_ADDI:     wordNext = encI(immSmall, rdFull, 3'b000, rdFull, OPC_OPIMM);
      OP_JAL:      wordNext = encJ(offJext, REG_LINK);
      OP_LI:       wordNext = encI(immSmall, REG_ZERO, 3'b000, rdFull, OPC_OPIMM);
      OP_ADDI16SP: wordNext = encI(immSp16, REG_SP, 3'b000, REG_SP, OPC_OPIMM);
      OP_LUI:      wordNext = {immUpper, rdFull, OPC_LUI};
      OP_SRLI:     wordNext = encI({7'b0000000, shamt}, rsComp, 3'b101, rsComp, OPC_OPIMM);
      OP_SRAI:     wordNext = encI({7'b0100000, shamt}, rsComp, 3'b101, rsComp, OPC_OPIMM);
      OP_ANDI:     wordNext = encI(immSmall, rsComp, 3'b111, rsComp, OPC_OPIMM);
      OP_SUB:      wordNext = encR(7'b0100000, rdComp, rsComp, 3'b000, rsComp);
      OP_XOR:      wordNext = encR(7'b0000000, rdComp, rsComp, 3'b100, rsComp);
      OP_OR:       wordNext = encR(7'b0000000, rdComp, rsComp, 3'b110, rsComp);
      OP_AND:      wordNext = encR(7'b0000000, rdComp, rsComp, 3'b111, rsComp);
      OP_J:        wordNext = encJ(offJext, REG_ZERO);
      OP_BEQZ:     wordNext = encB(offBext, rsComp, 3'b000);
      OP_BNEZ:     wordNext = encB(offBext, rsComp, 3'b001);
      OP_SLLI:     wordNext = encI({7'b0000000, shamt}, rdFull, 3'b001, rdFull, OPC_OPIMM);
      OP_LWSP:     wordNext = encI(immLwsp, REG_SP, 3'b010, rdFull, OPC_LOAD);
      OP_MV:       wordNext = encR(7'b0000000, rs2Full, REG_ZERO, 3'b000, rdFull);
      OP_JR:       wordNext = encI(12'd0, rdFull, 3'b000, REG_ZERO, OPC_JALR);
      OP_ADD:      wordNext = encR(7'b0000000, rs2Full, rdFull, 3'b000, rdFull);
      OP_JALR:     wordNext = encI(12'd0, rdFull, 3'b000, REG_LINK, OPC_JALR);
      OP_EBREAK:   wordNext = BREAK_WORD;
      OP_SWSP:     wordNext = encS(immSwsp, rs2Full, REG_SP);
      default:     wordNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outIllegal <= 1'b0;
      outInstr   <= '0;
    end else begin
      outValid   <= strobe.take;
      outIllegal <= strobe.take & strobe.bad;
      outInstr   <= (strobe.take && !strobe.bad) ? wordNext : '0;
    end
  end

  a_r1_valid_rises: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take |=> outValid);
  a_r1_valid_drops: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.take |=> !outValid);
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (outInstr == '0 && !outIllegal));
  a_r13_illegal_zero_word: assert property (@(posedge clk) disable iff (!rstN)
    outIllegal |-> outInstr == '0);
  a_r9_break_word: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.take && strobe.op == OP_EBREAK) |=> (outInstr == BREAK_WORD && !outIllegal));

endmodule

// File: rtl/cinstr_expand.sv
module cinstr_expand
  import cinstr_expand_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [HALF_W-1:0] inHalf,
  output logic              outValid,
  output logic [WORD_W-1:0] outInstr,
  output logic              outIllegal
);

  ctrlStrobe_t strobe;

  cinstr_expand_ctrl u_ctrl (
    .inValid (inValid),
    .half    (inHalf),
    .strobe  (strobe)
  );

  cinstr_expand_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .fld        (inHalf[12:2]),
    .strobe     (strobe),
    .outValid   (outValid),
    .outInstr   (outInstr),
    .outIllegal (outIllegal)
  );

endmodule

// File: tb/cinstr_expand_tb.sv
module cinstr_expand_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [15:0] inHalf = '0;
  logic        outValid;
  logic [31:0] outInstr;
  logic        outIllegal;

  int testCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cinstr_expand u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inHalf(inHalf),
    .outValid(outValid), .outInstr(outInstr), .outIllegal(outIllegal)
  );

  typedef struct packed {
    logic [15:0] half;
    logic        bad;
    logic [31:0] word;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 47;
  localparam vec_t VECS [NVEC] = '{
    '{16'h0001, 1'b0, 32'h0000_0013, 8'd7},   // R7 nop form of add-immediate
    '{16'h0085, 1'b0, 32'h0010_8093, 8'd7},   // R7 add-immediate x1 += 1
    '{16'h557D, 1'b0, 32'hFFF0_0513, 8'd7},   // R7 load-immediate -1
    '{16'h4080, 1'b0, 32'h0004_A403, 8'd3},   // R3 compact regs x8 / x9
    '{16'h40C0, 1'b0, 32'h0044_A403, 8'd4},   // R4 load offset bit 2
    '{16'h40A0, 1'b0, 32'h0404_A403, 8'd4},   // R4 load offset bit 6
    '{16'hC080, 1'b0, 32'h0084_A023, 8'd4},   // R4 store word
    '{16'h0040, 1'b0, 32'h0041_0413, 8'd4},   // R4 ADDI4SPN offset 4
    '{16'h4092, 1'b0, 32'h0041_2083, 8'd4},   // R4 stack load offset 4
    '{16'hC206, 1'b0, 32'h0011_2223, 8'd4},   // R4 stack store offset 4
    '{16'hA001, 1'b0, 32'h0000_006F, 8'd5},   // R5 jump zero offset
    '{16'hBFFD, 1'b0, 32'hFFFF_F06F, 8'd5},   // R5 jump -2
    '{16'h2009, 1'b0, 32'h0020_00EF, 8'd5},   // R5 linked jump +2
    '{16'h2005, 1'b0, 32'h0200_00EF, 8'd5},   // R5 linked jump +32
    '{16'hC001, 1'b0, 32'h0004_0063, 8'd6},   // R6 branch-equal zero
    '{16'hE009, 1'b0, 32'h0004_1163, 8'd6},   // R6 branch-not-equal +2
    '{16'hD001, 1'b0, 32'hF004_00E3, 8'd6},   // R6 branch -256
    '{16'h6085, 1'b0, 32'h0000_10B7, 8'd7},   // R7 load-upper 1
    '{16'h7081, 1'b0, 32'hFFFE_00B7, 8'd7},   // R7 load-upper negative
    '{16'h6141, 1'b0, 32'h0101_0113, 8'd10},  // R10 sp adjust +16
    '{16'h8005, 1'b0, 32'h0014_5413, 8'd7},   // R7 logical right shift
    '{16'h8405, 1'b0, 32'h4014_5413, 8'd7},   // R7 arithmetic right shift
    '{16'h987D, 1'b0, 32'hFFF4_7413, 8'd7},   // R7 and-immediate -1
    '{16'h0086, 1'b0, 32'h0010_9093, 8'd7},   // R7 left shift
    '{16'h8C05, 1'b0, 32'h4094_0433, 8'd8},   // R8 subtract
    '{16'h8C25, 1'b0, 32'h0094_4433, 8'd8},   // R8 xor
    '{16'h8C45, 1'b0, 32'h0094_6433, 8'd8},   // R8 or
    '{16'h8C65, 1'b0, 32'h0094_7433, 8'd8},   // R8 and
    '{16'h852E, 1'b0, 32'h00B0_0533, 8'd9},   // R9 move
    '{16'h952E, 1'b0, 32'h00B5_0533, 8'd9},   // R9 add
    '{16'h8082, 1'b0, 32'h0000_8067, 8'd9},   // R9 jump-register x0
    '{16'h9082, 1'b0, 32'h0000_80E7, 8'd9},   // R9 jump-register x1
    '{16'h9002, 1'b0, 32'h0010_0073, 8'd9},   // R9 breakpoint
    '{16'h0000, 1'b1, 32'h0, 8'd11},          // R11 all-zero word
    '{16'h0004, 1'b1, 32'h0, 8'd11},          // R11 ADDI4SPN zero offset
    '{16'h6081, 1'b1, 32'h0, 8'd11},          // R11 load-upper zero imm
    '{16'h6005, 1'b1, 32'h0, 8'd11},          // R11 load-upper rd 0
    '{16'h6101, 1'b1, 32'h0, 8'd11},          // R11 sp adjust zero
    '{16'h4005, 1'b1, 32'h0, 8'd11},          // R11 load-immediate rd 0
    '{16'h0006, 1'b1, 32'h0, 8'd11},          // R11 left shift rd 0
    '{16'h0003, 1'b1, 32'h0, 8'd12},          // R12 quadrant 3
    '{16'hFFFF, 1'b1, 32'h0, 8'd12},          // R12 quadrant 3 all ones
    '{16'h6000, 1'b1, 32'h0, 8'd12},          // R12 quadrant 0 fp load slot
    '{16'hE002, 1'b1, 32'h0, 8'd12},          // R12 quadrant 2 fp store slot
    '{16'h9005, 1'b1, 32'h0, 8'd12},          // R12 shift with bit 12
    '{16'h1086, 1'b1, 32'h0, 8'd12},          // R12 left shift with bit 12
    '{16'h9C05, 1'b1, 32'h0, 8'd12}           // R12 64-bit word subtract
  };

  task automatic check(input string req, input logic [33:0] act, input logic [33:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: got valid/illegal/instr %b/%b/%h expected %b/%b/%h",
               req, act[33], act[32], act[31:0], exp[33], exp[32], exp[31:0]);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    // R2 reset state
    repeat (3) @(negedge clk);
    check("R2 reset", {outValid, outIllegal, outInstr}, 34'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R2 idle after reset", {outValid, outIllegal, outInstr}, 34'd0);

    // R1 back-to-back stream through the vector table
    inValid = 1'b1;
    inHalf  = VECS[0].half;
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      check($sformatf("R%0d vector %0d half %h", VECS[i].req, i, VECS[i].half),
            {outValid, outIllegal, outInstr}, {1'b1, VECS[i].bad, VECS[i].word});
      if (i + 1 < NVEC) inHalf = VECS[i + 1].half;
    end

    // R2 illegal halfword without strobe has no effect
    inValid = 1'b0;
    inHalf  = 16'h0000;
    @(negedge clk);
    check("R2 no strobe, illegal half", {outValid, outIllegal, outInstr}, 34'd0);

    // R1 single isolated strobe, then drop
    inValid = 1'b1;
    inHalf  = 16'h9002;
    @(negedge clk);
    inValid = 1'b0;
    check("R1 isolated strobe", {outValid, outIllegal, outInstr}, {2'b10, 32'h0010_0073});
    @(negedge clk);
    check("R1 strobe drops", {outValid, outIllegal, outInstr}, 34'd0);

    // R13 illegal word after a legal one clears the instruction
    inValid = 1'b1;
    inHalf  = 16'h952E;
    @(negedge clk);
    inHalf  = 16'h6101;
    @(negedge clk);
    check("R13 illegal follows legal", {outValid, outIllegal, outInstr}, {2'b11, 32'h0});

    // R2 asynchronous reset in mid stream
    inHalf = 16'h0085;
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R2 async reset", {outValid, outIllegal, outInstr}, 34'd0);
    inValid = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R2 idle after second reset", {outValid, outIllegal, outInstr}, 34'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule